// File: doc/BRIEF.md
# Byte-Wide SRAM Chip-Enable Decoder

This block turns a processor-side memory access into the pin activity of a non-multiplexed byte-wide SRAM bus. A 17-bit access address is split into a 15-bit in-device address, which goes straight to the address pins, and a 2-bit block number, which picks one of four active-low chip enables, each covering 32kB. A mode input instead targets one 128kB device. In that mode the first enable selects the whole device, and the second and third enable pins carry address bits 16 and 15.

Blocks below a programmable partition boundary hold program memory and are write-protected. A write aimed at them produces no write strobe, leaves the data bus released and sets a sticky violation flag. A power-fail input forces every enable pin and the write strobe inactive at once, whatever access is under way.

Each accepted request is a two-cycle access. In the setup cycle, address and enables become valid one clock after the request. The strobe cycle follows, with the write strobe low for exactly that cycle when the write is permitted. A request made during the setup cycle is ignored. A request made during the strobe cycle starts the next access, so the bus can run back-to-back at one access every two cycles.

Top module: `sram_ce_decoder`

## Requirements
- R1: One clock after an accepted request, `sram_addr_o` equals bits 14..0 of `addr_i`. It holds that value until the next accepted request. Bits 14 and 13 are driven even when only an 8kB device is fitted.
- R2: With `mem_sel_i`=1 (four 32kB devices), an access drives low exactly one bit of `sram_ce_no`: bit index = `addr_i[16:15]`. Bit 0 is the primary enable. Outside an access all four bits are high.
- R3: With `mem_sel_i`=0 (one 128kB device), an access drives `sram_ce_no[0]` low, `sram_ce_no[1]` = `addr_i[16]`, `sram_ce_no[2]` = `addr_i[15]` and `sram_ce_no[3]` high.
- R4: For a permitted write, `sram_we_no` is low for exactly one cycle, the second cycle of the access. A write is permitted when `addr_i[16:15]` >= `part_bound_i`. Reads never drive `sram_we_no` low.
- R5: A write with `addr_i[16:15]` < `part_bound_i` never drives `sram_we_no` low. It sets `wr_viol_o`, visible one cycle after the request, and the flag stays set until reset.
- R6: While `pwr_fail_i` is 1, all four `sram_ce_no` bits and `sram_we_no` are high in the same cycle.
- R7: The block drives `sram_data_io` with the write data only during both cycles of a permitted write. At all other times the bus is released. `rdata_o` always shows the bus value.
- R8: During reset, `sram_ce_no` is 4'hF, `sram_we_no` is 1, `wr_viol_o` is 0, `busy_o` is 0 and the data bus is released.
- R9: `busy_o` is 1 in the setup cycle of an access, and a request in that cycle is ignored. A request in the strobe cycle starts a new access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 17 | Access address; bits 16..15 are the block number |
| wdata_i | input | 8 | Write data |
| mem_sel_i | input | 1 | 1 = four 32kB devices, 0 = one 128kB device |
| part_bound_i | input | 3 | First data block; lower blocks are program |
| pwr_fail_i | input | 1 | Supply below threshold |
| sram_addr_o | output | 15 | SRAM address pins |
| sram_data_io | inout | 8 | SRAM data bus |
| sram_we_no | output | 1 | Active-low write strobe |
| sram_ce_no | output | 4 | Active-low chip enables (bits 1 and 2 are address lines in 128kB mode) |
| rdata_o | output | 8 | Value seen on the data bus |
| busy_o | output | 1 | Setup cycle in progress; requests ignored |
| wr_viol_o | output | 1 | Sticky write-protection violation |

## Verification
The bench targets the following corner cases, each with the failure it would expose:
- **Partition boundary at each block value, including 0 and 4.** An off-by-one in the comparison would strobe a program block, or lock out the first data block.
- **Both memory modes with every block number.** Swapping the two address bits carried on the enable pins would scramble the 128kB device's address map. Leaving a one-hot enable active in 128kB mode would select the wrong device.
- **Power-fail asserted in the middle of a write.** A design that only gated at the next clock edge would leave an enable or the strobe low for a cycle.
- **A request held high for many cycles.** A design that accepted it in the setup cycle would cut the strobe short or drop it entirely.

// File: rtl/sram_dec_pkg.sv
package sram_dec_pkg;
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SETUP  = 2'd1,
    PH_STROBE = 2'd2
  } phase_e;
endpackage

// File: rtl/sram_blk_decode.sv
module sram_blk_decode #(
  parameter int BLK_W = 2,
  localparam int N_CE = 1 << BLK_W
) (
  input  logic [BLK_W-1:0] blk_i,
  input  logic             mode32_i,
  input  logic [BLK_W:0]   bound_i,
  output logic [N_CE-1:0]  ce_pat_o,
  output logic             is_prog_o
);
  logic [N_CE-1:0] onehot_n;
  logic [N_CE-1:0] wide_n;

  for (genvar g = 0; g < N_CE; g++) begin : g_onehot
    assign onehot_n[g] = (blk_i != BLK_W'(g));
  end

  // single large device: CE1 selects it, next pins carry block bits MSB first
  if (BLK_W == 2) begin : g_wide2
    assign wide_n = {1'b1, blk_i[0], blk_i[1], 1'b0};
  end else begin : g_wide_other
    assign wide_n = {{(N_CE-1){1'b1}}, 1'b0};
  end

  assign ce_pat_o  = mode32_i ? onehot_n : wide_n;
  assign is_prog_o = ({1'b0, blk_i} < bound_i);
endmodule

// File: rtl/sram_access_seq.sv
module sram_access_seq
  import sram_dec_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8,
  parameter int N_CE   = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              mode32_i,
  input  logic [N_CE-1:0]   ce_pat_i,
  input  logic              is_prog_i,
  output logic [ADDR_W-1:0] addr_q_o,
  output logic [N_CE-1:0]   ce_q_o,
  output logic [DATA_W-1:0] data_q_o,
  output logic              oe_q_o,
  output logic              we_n_q_o,
  output logic              viol_q_o,
  output logic              busy_o,
  output logic              mode32_q_o
);
  phase_e state_q, state_d;
  logic   accept, ok_q;

  assign accept = req_i && (state_q != PH_SETUP);
  assign busy_o = (state_q == PH_SETUP);

  always_comb begin
    state_d = PH_IDLE;
    if (accept)                   state_d = PH_SETUP;
    else if (state_q == PH_SETUP) state_d = PH_STROBE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= PH_IDLE;
      addr_q_o   <= '0;
      ce_q_o     <= '1;
      data_q_o   <= '0;
      oe_q_o     <= 1'b0;
      ok_q       <= 1'b0;
      we_n_q_o   <= 1'b1;
      viol_q_o   <= 1'b0;
      mode32_q_o <= 1'b1;
    end else begin
      state_q  <= state_d;
      we_n_q_o <= !((state_q == PH_SETUP) && ok_q);
      if (accept) begin
        addr_q_o   <= addr_i;
        ce_q_o     <= ce_pat_i;
        data_q_o   <= wdata_i;
        ok_q       <= we_i && !is_prog_i;
        oe_q_o     <= we_i && !is_prog_i;
        mode32_q_o <= mode32_i;
        if (we_i && is_prog_i) viol_q_o <= 1'b1;
      end else if (state_q != PH_SETUP) begin
        ce_q_o <= '1;
        oe_q_o <= 1'b0;
        ok_q   <= 1'b0;
      end
    end
  end

  // R4
  we_one_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_n_q_o |=> we_n_q_o);
  // R4
  we_after_setup_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(we_n_q_o) |-> $past(state_q) == PH_SETUP);
  // R5
  viol_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    viol_q_o |=> viol_q_o);
  // R9
  setup_then_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> (state_q == PH_STROBE) && $stable(addr_q_o));
  // R7
  oe_with_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_n_q_o |-> oe_q_o);
endmodule

// File: rtl/sram_ce_decoder.sv
module sram_ce_decoder
  import sram_dec_pkg::*;
#(
  parameter int ADDR_W      = 17,
  parameter int BANK_ADDR_W = 15,
  parameter int DATA_W      = 8,
  localparam int BLK_W      = ADDR_W - BANK_ADDR_W,
  localparam int N_CE       = 1 << BLK_W
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   req_i,
  input  logic                   we_i,
  input  logic [ADDR_W-1:0]      addr_i,
  input  logic [DATA_W-1:0]      wdata_i,
  input  logic                   mem_sel_i,
  input  logic [BLK_W:0]         part_bound_i,
  input  logic                   pwr_fail_i,
  output logic [BANK_ADDR_W-1:0] sram_addr_o,
  inout  wire  [DATA_W-1:0]      sram_data_io,
  output logic                   sram_we_no,
  output logic [N_CE-1:0]        sram_ce_no,
  output logic [DATA_W-1:0]      rdata_o,
  output logic                   busy_o,
  output logic                   wr_viol_o
);
  logic [N_CE-1:0]   ce_pat, ce_q;
  logic              is_prog, oe_q, we_n_q, mode32_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;

  sram_blk_decode #(.BLK_W(BLK_W)) u_dec (
    .blk_i     (addr_i[ADDR_W-1:BANK_ADDR_W]),
    .mode32_i  (mem_sel_i),
    .bound_i   (part_bound_i),
    .ce_pat_o  (ce_pat),
    .is_prog_o (is_prog)
  );

  sram_access_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .N_CE(N_CE)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (req_i),
    .we_i       (we_i),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .mode32_i   (mem_sel_i),
    .ce_pat_i   (ce_pat),
    .is_prog_i  (is_prog),
    .addr_q_o   (addr_q),
    .ce_q_o     (ce_q),
    .data_q_o   (data_q),
    .oe_q_o     (oe_q),
    .we_n_q_o   (we_n_q),
    .viol_q_o   (wr_viol_o),
    .busy_o     (busy_o),
    .mode32_q_o (mode32_q)
  );

  assign sram_addr_o  = addr_q[BANK_ADDR_W-1:0];
  // supply loss overrides registered state without waiting for a clock
  assign sram_ce_no   = ce_q | {N_CE{pwr_fail_i}};
  assign sram_we_no   = we_n_q | pwr_fail_i;
  assign sram_data_io = oe_q ? data_q : {DATA_W{1'bz}};
  assign rdata_o      = sram_data_io;

  // R6
  pwr_fail_ce_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwr_fail_i |-> (&sram_ce_no) && sram_we_no);
  // R2
  ce_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode32_q |-> $onehot0(~sram_ce_no));
  // R3
  wide_ce4_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode32_q |-> sram_ce_no[N_CE-1]);
endmodule

// File: tb/sram_ce_decoder_tb.sv
`timescale 1ns/1ps
module sram_ce_decoder_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0, mem_sel = 1'b1, pwr = 1'b0;
  logic [16:0] addr = '0;
  logic [7:0]  wdata = '0, tb_val = 8'h5a;
  logic [2:0]  bound = '0;
  logic [14:0] sram_addr;
  logic        sram_we_n, busy, viol;
  logic [3:0]  sram_ce_n;
  logic [7:0]  rdata;
  wire  [7:0]  sram_data;
  bit          tb_oe = 1'b1;
  int          errors = 0, checks = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  assign sram_data = tb_oe ? tb_val : 8'hzz;

  sram_ce_decoder u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .mem_sel_i(mem_sel), .part_bound_i(bound),
    .pwr_fail_i(pwr), .sram_addr_o(sram_addr), .sram_data_io(sram_data),
    .sram_we_no(sram_we_n), .sram_ce_no(sram_ce_n), .rdata_o(rdata),
    .busy_o(busy), .wr_viol_o(viol)
  );

  task automatic check(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", rq, act, exp, $time);
    end
  endtask

  // behavioural reference
  int          ph = 0;
  logic [16:0] m_a = '0;
  logic [7:0]  m_d = '0;
  bit          m_ok = 0, m_viol = 0, m_mode = 1;

  function automatic logic [3:0] exp_ce(input logic [1:0] b, input bit m32);
    if (m32) return ~(4'b0001 << b);
    return {1'b1, b[0], b[1], 1'b0};
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph = 0; m_a = '0; m_ok = 0; m_viol = 0; m_mode = 1;
    end else begin
      if (ph != 1 && req) begin
        ph = 1; m_a = addr; m_d = wdata; m_mode = mem_sel;
        m_ok = we && (int'(addr[16:15]) >= int'(bound));
        if (we && int'(addr[16:15]) < int'(bound)) m_viol = 1;
      end else if (ph == 1) ph = 2;
      else begin ph = 0; m_ok = 0; end
    end
    tb_oe = !(ph != 0 && m_ok);
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [3:0] ce_e;
      bit         we_e;
      string      ce_r;
      ce_e = (ph == 0) ? 4'hf : exp_ce(m_a[16:15], m_mode);
      ce_r = pwr ? "R6" : (ph == 0 ? "R2" : (m_mode ? "R2" : "R3"));
      if (pwr) ce_e = 4'hf;
      we_e = !(ph == 2 && m_ok && !pwr);
      check(sram_addr == m_a[14:0], "R1", sram_addr, m_a[14:0]);
      check(sram_ce_n == ce_e, ce_r, sram_ce_n, ce_e);
      check(sram_we_n == we_e, pwr ? "R6" : "R4", sram_we_n, we_e);
      check(viol == m_viol, "R5", viol, m_viol);
      check(busy == (ph == 1), "R9", busy, ph == 1);
      if (ph != 0 && m_ok) check(rdata == m_d, "R7", rdata, m_d);
      else                 check(rdata == tb_val, "R7", rdata, tb_val);
    end
  end

  task automatic acc(input bit w, input logic [16:0] a, input logic [7:0] d);
    @(negedge clk); #1;
    req = 1'b1; we = w; addr = a; wdata = d; tb_val = ~d;
    @(negedge clk); #1;
    req = 1'b0;
    @(negedge clk); #1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R8 reset state
    check(sram_ce_n == 4'hf, "R8", sram_ce_n, 4'hf);
    check(sram_we_n == 1'b1, "R8", sram_we_n, 1);
    check(viol == 1'b0, "R8", viol, 0);
    check(busy == 1'b0, "R8", busy, 0);
    check(rdata == tb_val, "R8", rdata, tb_val);
    #1 rst_n = 1'b1;
    // R2 R4 R7: four 32kB devices, no protection
    for (int b = 0; b < 4; b++) acc(1'b1, {b[1:0], 15'h1234 + 15'(b * 977)}, 8'(8'h30 + b));
    for (int b = 0; b < 4; b++) acc(1'b0, {b[1:0], 15'h7fff - 15'(b)}, 8'h00);
    // R1 8kB-style addresses still drive bits 14..13
    acc(1'b0, 17'h06000, 8'h00);
    // R5 sweep the partition boundary
    for (int bd = 0; bd <= 4; bd++) begin
      bound = 3'(bd);
      for (int b = 0; b < 4; b++) acc(1'b1, {b[1:0], 15'(bd * 1000 + b)}, 8'(bd * 16 + b));
    end
    // R3 one 128kB device
    mem_sel = 1'b0;
    bound = 3'd1;
    for (int b = 0; b < 4; b++) acc(1'b1, {b[1:0], 15'h0abc}, 8'(8'hc0 + b));
    for (int b = 0; b < 4; b++) acc(1'b0, {b[1:0], 15'h0123}, 8'h00);
    // R6 power fail across a write
    mem_sel = 1'b1;
    @(negedge clk); #1; req = 1'b1; we = 1'b1; addr = 17'h18000; wdata = 8'h99;
    @(negedge clk); #1; req = 1'b0; pwr = 1'b1;
    repeat (3) @(negedge clk);
    #1 pwr = 1'b0;
    acc(1'b1, 17'h1c001, 8'h77);
    // R9 held request: back-to-back accesses, setup-cycle requests ignored
    @(negedge clk); #1; req = 1'b1; we = 1'b1; addr = 17'h10042; wdata = 8'h42;
    repeat (3) begin
      @(negedge clk); #1; addr = addr + 17'h08000; wdata = wdata + 8'd1;
    end
    repeat (4) begin
      @(negedge clk); #1; we = 1'b0; addr = addr + 17'h00100;
    end
    req = 1'b0;
    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule